// File: doc/BRIEF.md
# Control Cell Processor Mailbox

The mailbox lets a local processor exchange control cells with a cell bus through a byte-wide memory-mapped port. To send, the processor fills a 56-byte transmit buffer and then sets a send-request flag in a command/status register. The block streams the buffered cell, byte by byte, to the cell bus transmitter. When the last byte has been accepted, the flag drops by itself, and the buffer may then be refilled.

Control cells that the receive filter has already accepted arrive as a byte stream. Up to four of them queue inside the block. The processor sees the oldest queued cell through a fixed 52-byte read window. It writes a pop command to discard that cell, which brings the next one into the window. Reads are combinational: `cpu_rdata` follows `cpu_addr` in the same cycle.

Top module: `ctl_cell_mailbox`

## Requirements
- R1: After reset the command/status register at 0x110 reads 0x04 (only the empty flag set), and `tx_valid` is low.
- R2: Transmit buffer byte i sits at address 0xA0+i, for i from 0 to 55. The processor can write it and read it back.
- R3: Writing 0x110 with bit 0 = 1 while idle sets the send flag, which reads back in bit 0. From the next cycle the stream presents buffer bytes 0 to 55 in order, with `tx_last` on byte 55. The stream advances only on `tx_valid && tx_ready` and holds its data while `tx_ready` is low.
- R4: The cycle after the handshake of the byte with `tx_last`, the send flag reads 0 and `tx_valid` is low.
- R5: While the send flag is set, processor writes to 0xA0–0xD7 are ignored. The buffer contents read back unchanged.
- R6: Bytes on the receive stream fill a cell in order, and the cell is queued on the byte with `rx_last`. Address 0x60+i shows byte i of the oldest queued cell, for i from 0 to 51. Bit 2 of 0x110 reads 1 exactly when no cell is queued.
- R7: The queue holds four cells, and the window always shows the oldest one.
- R8: Writing 0x110 with bit 1 = 1 removes the oldest cell. Bit 1 always reads 0.
- R9: A pop command while the queue is empty changes nothing. Later cells are queued and shown normally.
- R10: A cell whose first byte arrives while four cells are queued is dropped whole. Bit 3 of 0x110 is then set and stays set until 0x110 is written with bit 3 = 1.
- R11: Addresses outside 0x60–0x93, 0xA0–0xD7 and 0x110 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 9 | Processor byte address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, combinational from `cpu_addr` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the cell |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of a received cell |

## Verification
The bench stalls the transmit stream with `tx_ready` held low and writes into the buffer while a send is pending. A design that let the data move under a stall would skip bytes, and one that accepted the write would send a corrupted cell. The bench fills the receive queue, then sends a fifth cell. A design that overwrote a queued cell or failed to set the overflow flag would show the wrong head bytes or a clear bit 3. The bench also pops an empty queue and then queues a new cell. A design that let the occupancy counter wrap would report a non-empty queue or show a stale cell in the window.

// File: rtl/ccm_pkg.sv
// Shared definitions for the control cell mailbox.
// Assumes: a byte-wide processor port; register bit positions are fixed here.
package ccm_pkg;
    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_TX,
        RGN_RX,
        RGN_CTRL
    } rgn_e;

    localparam int CTL_SEND_BIT  = 0;
    localparam int CTL_POP_BIT   = 1;
    localparam int CTL_EMPTY_BIT = 2;
    localparam int CTL_OVF_BIT   = 3;
endpackage

// File: rtl/ccm_addr_dec.sv
// Address decoder: maps a processor byte address to a region and an in-window offset.
// Assumes: the two windows and the register do not overlap.
module ccm_addr_dec
    import ccm_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int TX_BASE   = 'hA0,
    parameter int TX_BYTES  = 56,
    parameter int RX_BASE   = 'h60,
    parameter int RX_BYTES  = 52,
    parameter int CTRL_ADDR = 'h110,
    localparam int TX_OFF_W = $clog2(TX_BYTES),
    localparam int RX_OFF_W = $clog2(RX_BYTES)
) (
    input  logic [ADDR_W-1:0]   addr,
    output rgn_e                rgn,
    output logic [TX_OFF_W-1:0] tx_off,
    output logic [RX_OFF_W-1:0] rx_off
);
    localparam logic [ADDR_W-1:0] TX_LO = ADDR_W'(TX_BASE);
    localparam logic [ADDR_W-1:0] TX_HI = ADDR_W'(TX_BASE + TX_BYTES - 1);
    localparam logic [ADDR_W-1:0] RX_LO = ADDR_W'(RX_BASE);
    localparam logic [ADDR_W-1:0] RX_HI = ADDR_W'(RX_BASE + RX_BYTES - 1);
    localparam logic [ADDR_W-1:0] CT_AD = ADDR_W'(CTRL_ADDR);

    // Region select from address ranges.
    always_comb begin
        rgn = RGN_NONE;
        if (addr >= TX_LO && addr <= TX_HI)      rgn = RGN_TX;
        else if (addr >= RX_LO && addr <= RX_HI) rgn = RGN_RX;
        else if (addr == CT_AD)                  rgn = RGN_CTRL;
    end

    // Offsets inside each window; only meaningful when the region matches.
    assign tx_off = TX_OFF_W'(addr - TX_LO);
    assign rx_off = RX_OFF_W'(addr - RX_LO);
endmodule

// File: rtl/ccm_tx_buf.sv
// Transmit cell buffer and byte streamer.
// Holds one cell. A start pulse launches streaming; the busy flag clears after the last
// byte is accepted. Processor writes are blocked while busy.
// Assumes: start is ignored while busy.
module ccm_tx_buf #(
    parameter int TX_BYTES = 56,
    localparam int IDX_W   = $clog2(TX_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] off,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic             start,
    output logic             busy,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TX_BYTES - 1);

    logic [7:0]       mem [TX_BYTES];
    logic [IDX_W-1:0] idx;

    // Buffer storage: processor writes land only when not sending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TX_BYTES; i++) mem[i] <= '0;
        end else if (wr_en && !busy) begin
            mem[off] <= wr_data;
        end
    end

    // Send sequencer: launch on start, step on handshake, finish after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            busy <= start;
            idx  <= '0;
        end else if (tx_ready) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign tx_valid = busy;
    assign tx_data  = mem[idx];
    assign tx_last  = busy && (idx == LAST_IDX);
    assign rd_data  = mem[off];

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !busy && !tx_valid);
    p_start_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> !tx_last);
endmodule

// File: rtl/ccm_rx_fifo.sv
// Receive cell queue with a head read window.
// Cells are written byte by byte into the next free slot. A cell is queued on its last byte.
// Whether to accept a cell is decided at its first byte: when the queue is full, the whole
// cell is dropped and a sticky overflow flag is set.
// Assumes: bytes beyond the cell size are discarded.
module ccm_rx_fifo #(
    parameter int DEPTH      = 4,
    parameter int CELL_BYTES = 52,
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int IDX_W     = $clog2(CELL_BYTES + 1),
    localparam int OFF_W     = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             pop_req,
    input  logic             ovf_clr,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data,
    output logic             empty,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(CELL_BYTES);

    logic [7:0]       mem [DEPTH][CELL_BYTES];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             acc_q, full, first, take, wr_byte, push, pop;

    assign full    = (cnt == CNT_FULL);
    assign first   = (idx == '0);
    assign take    = first ? !full : acc_q;
    assign wr_byte = in_valid && take && (idx < IDX_END);
    assign push    = in_valid && in_last && take;
    assign pop     = pop_req && !empty;
    assign empty   = (cnt == '0);

    // Byte position inside the incoming cell and the accept decision taken at its first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            acc_q <= 1'b0;
        end else if (in_valid) begin
            if (first) acc_q <= !full;
            if (in_last)              idx <= '0;
            else if (idx < IDX_END)   idx <= idx + 1'b1;
        end
    end

    // Cell storage write into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_byte) mem[wr_ptr][OFF_W'(idx)] <= in_data;
    end

    // Queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Sticky overflow flag: set on a dropped cell, cleared by request; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                         overflow <= 1'b0;
        else if (in_valid && first && full) overflow <= 1'b1;
        else if (ovf_clr)                   overflow <= 1'b0;
    end

    assign rd_data = mem[rd_ptr][rd_off];

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && empty && !push |=> empty);
    p_drop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && first && full |=> overflow);
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !ovf_clr |=> overflow);
endmodule

// File: rtl/ctl_cell_mailbox.sv
// Control cell processor mailbox: transmit buffer, receive queue and the command/status register.
// Register: bit0 send request (set by write 1, cleared by hardware), bit1 pop (write-1 pulse,
// reads 0), bit2 queue empty, bit3 sticky overflow (write 1 clears).
// Assumes: reads are combinational and unmapped addresses read zero.
module ctl_cell_mailbox
    import ccm_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int TX_BASE   = 'hA0,
    parameter int TX_BYTES  = 56,
    parameter int RX_BASE   = 'h60,
    parameter int RX_BYTES  = 52,
    parameter int CTRL_ADDR = 'h110,
    parameter int RX_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last
);
    localparam int TX_OFF_W = $clog2(TX_BYTES);
    localparam int RX_OFF_W = $clog2(RX_BYTES);

    rgn_e                rgn;
    logic [TX_OFF_W-1:0] tx_off;
    logic [RX_OFF_W-1:0] rx_off;
    logic [7:0]          tx_rd, rx_rd, ctl_rd;
    logic                busy, empty, overflow, ctl_wr;
    logic                unused_wdata;

    ccm_addr_dec #(
        .ADDR_W(ADDR_W), .TX_BASE(TX_BASE), .TX_BYTES(TX_BYTES),
        .RX_BASE(RX_BASE), .RX_BYTES(RX_BYTES), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(cpu_addr), .rgn(rgn), .tx_off(tx_off), .rx_off(rx_off)
    );

    assign ctl_wr       = cpu_wr && (rgn == RGN_CTRL);
    assign unused_wdata = &{cpu_wdata[7:4], cpu_wdata[CTL_EMPTY_BIT]};

    ccm_tx_buf #(.TX_BYTES(TX_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cpu_wr && (rgn == RGN_TX)), .off(tx_off), .wr_data(cpu_wdata),
        .rd_data(tx_rd),
        .start(ctl_wr && cpu_wdata[CTL_SEND_BIT]), .busy(busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
    );

    ccm_rx_fifo #(.DEPTH(RX_DEPTH), .CELL_BYTES(RX_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last),
        .pop_req(ctl_wr && cpu_wdata[CTL_POP_BIT]),
        .ovf_clr(ctl_wr && cpu_wdata[CTL_OVF_BIT]),
        .rd_off(rx_off), .rd_data(rx_rd), .empty(empty), .overflow(overflow)
    );

    // Status byte assembly; the pop bit is a pulse and reads as zero.
    always_comb begin
        ctl_rd                = '0;
        ctl_rd[CTL_SEND_BIT]  = busy;
        ctl_rd[CTL_EMPTY_BIT] = empty;
        ctl_rd[CTL_OVF_BIT]   = overflow;
    end

    // Read data multiplexer by decoded region.
    always_comb begin
        unique case (rgn)
            RGN_TX:   cpu_rdata = tx_rd;
            RGN_RX:   cpu_rdata = rx_rd;
            RGN_CTRL: cpu_rdata = ctl_rd;
            default:  cpu_rdata = '0;
        endcase
    end

    p_pop_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rgn == RGN_CTRL |-> !cpu_rdata[CTL_POP_BIT]);
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rgn == RGN_NONE |-> cpu_rdata == 8'h00);
    p_send_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && cpu_wdata[CTL_SEND_BIT] |=> busy);
endmodule

// File: tb/ctl_cell_mailbox_bench.sv
module ctl_cell_mailbox_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       tx_valid, tx_last;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_last = 1'b0;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctl_cell_mailbox u_ctl_cell_mailbox (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    // Vector: {is_write, addr[8:0], data/expected[7:0], requirement[3:0]}
    localparam int NVEC = 12;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 9'h0A0, 8'h11, 4'd2},   // R2 first buffer byte
        {1'b0, 9'h0A0, 8'h11, 4'd2},
        {1'b1, 9'h0D7, 8'h5A, 4'd2},   // R2 last buffer byte
        {1'b0, 9'h0D7, 8'h5A, 4'd2},
        {1'b1, 9'h0B3, 8'hC4, 4'd2},
        {1'b0, 9'h0B3, 8'hC4, 4'd2},
        {1'b0, 9'h000, 8'h00, 4'd11},  // R11 unmapped reads zero
        {1'b1, 9'h050, 8'hFF, 4'd11},
        {1'b0, 9'h050, 8'h00, 4'd11},
        {1'b1, 9'h0D8, 8'h77, 4'd11},  // R11 just past the buffer
        {1'b0, 9'h0D8, 8'h00, 4'd11},
        {1'b0, 9'h094, 8'h00, 4'd11}   // R11 gap after the receive window
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_check(input logic [8:0] a, input logic [7:0] exp, input string req);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
        chk(req, cpu_rdata, exp);
    endtask

    task automatic send_cell(input logic [7:0] seed);
        for (int i = 0; i < 52; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == 51);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    function automatic logic [7:0] txpat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic string rtag(input int n);
        return $sformatf("R%0d", n);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cpu_check(9'h110, 8'h04, "R1 ctrl reset");
        chk("R1 tx_valid reset", {7'b0, tx_valid}, 8'h00);

        // Vector table: buffer access and unmapped space
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][21]) cpu_write(VEC[v][20:12], VEC[v][11:4]);
            else            cpu_check(VEC[v][20:12], VEC[v][11:4], rtag(int'(VEC[v][3:0])));
        end

        // R3 fill buffer, launch with the transmitter stalled
        for (int i = 0; i < 56; i++) cpu_write(9'(9'h0A0 + i), txpat(i));
        cpu_write(9'h110, 8'h01);
        cpu_check(9'h110, 8'h05, "R3 send flag set");
        chk("R3 valid after start", {7'b0, tx_valid}, 8'h01);
        chk("R3 first byte", tx_data, txpat(0));

        // R5 write while sending is ignored
        cpu_write(9'h0A0, 8'hEE);
        cpu_write(9'h0D7, 8'hEE);
        cpu_check(9'h0A0, txpat(0), "R5 buffer locked first");
        cpu_check(9'h0D7, txpat(55), "R5 buffer locked last");
        chk("R3 held under stall", tx_data, txpat(0));

        // R3 stream the cell, R4 completion
        tx_ready = 1'b1;
        for (int k = 0; k < 56; k++) begin
            chk("R3 stream byte", tx_data, txpat(k));
            chk("R3 last marker", {7'b0, tx_last}, (k == 55) ? 8'h01 : 8'h00);
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R4 valid drops", {7'b0, tx_valid}, 8'h00);
        cpu_check(9'h110, 8'h04, "R4 send flag cleared");
        cpu_write(9'h0A0, 8'h9C);
        cpu_check(9'h0A0, 8'h9C, "R4 buffer reusable");

        // R6 one received cell
        send_cell(8'h10);
        cpu_check(9'h110, 8'h00, "R6 not empty");
        cpu_check(9'h060, 8'h10, "R6 head byte 0");
        cpu_check(9'h093, 8'h43, "R6 head byte 51");

        // R7 fill to four, R10 fifth cell dropped
        send_cell(8'h40);
        send_cell(8'h70);
        send_cell(8'hA0);
        cpu_check(9'h060, 8'h10, "R7 head stays oldest");
        send_cell(8'hC0);
        cpu_check(9'h110, 8'h08, "R10 overflow set");
        cpu_check(9'h060, 8'h10, "R10 head intact");

        // R8 pops walk the queue in order
        cpu_write(9'h110, 8'h02);
        cpu_check(9'h110, 8'h08, "R8 pop bit reads zero");
        cpu_check(9'h060, 8'h40, "R8 second cell byte 0");
        cpu_check(9'h093, 8'h73, "R8 second cell byte 51");
        cpu_write(9'h110, 8'h02);
        cpu_check(9'h060, 8'h70, "R7 third cell");
        cpu_write(9'h110, 8'h02);
        cpu_check(9'h060, 8'hA0, "R7 fourth cell");
        cpu_write(9'h110, 8'h02);
        cpu_check(9'h110, 8'h0C, "R10 empty with sticky overflow");

        // R9 pop on empty does nothing
        cpu_write(9'h110, 8'h02);
        cpu_check(9'h110, 8'h0C, "R9 pop on empty");
        send_cell(8'h33);
        cpu_check(9'h110, 8'h08, "R9 one cell after empty pop");
        cpu_check(9'h060, 8'h33, "R9 new cell at head");
        cpu_write(9'h110, 8'h02);
        cpu_check(9'h110, 8'h0C, "R9 single cell removed");

        // R10 clear overflow
        cpu_write(9'h110, 8'h08);
        cpu_check(9'h110, 8'h04, "R10 overflow cleared");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule